// File: doc/BRIEF.md
# Fast-Skip Program Counter Advance Unit

This unit tracks a mask-driven skip sequence and, in its fast mode, lets the fetch stage jump over a run of skipped instructions in one step instead of squashing them one at a time. A skip instruction loads a mask in which bit 0 stands for the first instruction after it, bit 1 for the second, and so on. For every issue slot the unit reports whether the current instruction is squashed, and it reports how far the program counter moves past that slot: one, plus the number of directly following set bits that may be dropped outright, at no cost in cycles.

Fast elimination has fixed limits. It never applies to the first slot after the skip instruction. It drops at most seven instructions per step. It is switched off while fetching from shared main memory, where every set bit is squashed the ordinary way. Whenever a slot that carries a set bit is reached without having been eliminated, the unit raises a flag so the sequencer gives that slot normal squash timing. A new skip instruction always replaces any sequence in progress, and loading an all-zero mask ends skipping.

Top module: `fskip_advance`

## Requirements
- R1: While reset is asserted and right after it, `mask_o` is 0, `squash_o`, `slow_o` and `active_o` are 0 and `pc_inc_o` is 1.
- R2: A cycle with `start_i` high loads `mask_i` into `mask_o` at the next clock edge, with bit 0 being the slot right after the skip instruction; `squash_o` equals `mask_o` bit 0; in a cycle with neither `start_i` nor `adv_i`, `mask_i` and `fast_i` have no effect and `mask_o` keeps its value.
- R3: The first slot is never eliminated: after a load, `slow_o` equals bit 0 of the loaded mask, in both modes.
- R4: In fast mode (`fast_i` was 1 at load) with `shared_i` low, `pc_inc_o` is 1 plus the count of consecutive set bits of `mask_o` starting at bit 1, counted up to a limit of 7, so it ranges from 1 to 8.
- R5: With `shared_i` high, or in normal mode (`fast_i` was 0 at load), `pc_inc_o` is 1.
- R6: In a cycle with `adv_i` high and `start_i` low, `mask_o` becomes `mask_o` shifted right, filling with zeros, by the `pc_inc_o` of that cycle.
- R7: After such an advance, `slow_o` is 1 exactly when the new bit 0 is set and the step was limited to 7 eliminations, or `shared_i` was high, or the sequence is in normal mode; otherwise it is 0.
- R8: When `start_i` and `adv_i` are high in the same cycle, the load wins and any active sequence is replaced by the new mask.
- R9: `active_o` is 1 exactly when `mask_o` is nonzero; loading a zero mask ends skipping and leaves `pc_inc_o` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | A skip instruction executes this cycle |
| fast_i | input | 1 | The skip instruction is the fast variant |
| mask_i | input | MASK_W | Skip mask carried by the skip instruction |
| adv_i | input | 1 | The sequencer moves past the current slot |
| shared_i | input | 1 | Instructions are fetched from shared main memory |
| pc_inc_o | output | INC_W | Program counter increment past the current slot, in instructions |
| mask_o | output | MASK_W | Remaining mask, bit 0 is the current slot |
| squash_o | output | 1 | Current slot is squashed with normal timing |
| slow_o | output | 1 | Current slot was reached with its bit set and not eliminated |
| active_o | output | 1 | A skip sequence has bits left |

## Verification
A new load and an advance can fall in the same cycle, and so can the seven-instruction limit and a switch into shared memory. The bench drives `start_i` together with `adv_i` both in directed cases and on random cycles, and judges that the mask, mode and slow flag all come from the new load with no trace of a shift. A slot-by-slot reference model, run with random masks and random toggling of `shared_i`, predicts the increment, the remaining mask and the slow flag for every slot, so a capped run that ends in shared memory is judged the same way as any other step.

// File: rtl/fskip_pkg.sv
package fskip_pkg;

    // Default width of a skip mask, in instruction slots.
    parameter int FSK_MASK_W  = 32;
    // Default largest number of slots dropped in one program counter step.
    parameter int FSK_MAX_RUN = 7;

    // Width needed to hold an increment of 1 .. max_run + 1.
    function automatic int fsk_inc_width(input int max_run);
        return $clog2(max_run + 2);
    endfunction

endpackage

// File: rtl/fskip_run_count.sv
// Counts consecutive set bits of the mask starting at bit 1 (the slot
// after the current one), up to MAX_RUN. Returns zero when disabled.
module fskip_run_count #(
    parameter int MASK_W  = 32,
    parameter int MAX_RUN = 7,
    parameter int INC_W   = 4
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic              enable_i,
    output logic [INC_W-1:0]  run_o,
    output logic              capped_o
);

    // therm[k] is set when slots 1 .. k+1 all carry a set bit.
    logic [MAX_RUN-1:0] therm;

    genvar k;
    generate
        for (k = 0; k < MAX_RUN; k++) begin : g_therm
            if (k == 0) begin : g_first
                assign therm[k] = mask_i[1];
            end else begin : g_chain
                assign therm[k] = therm[k-1] & mask_i[k+1];
            end
        end
    endgenerate

    logic [INC_W-1:0] count;

    always_comb begin
        count = '0;
        for (int i = 0; i < MAX_RUN; i++) begin
            count = count + INC_W'(therm[i]);
        end
    end

    assign run_o    = enable_i ? count : '0;
    assign capped_o = enable_i & therm[MAX_RUN-1];

endmodule

// File: rtl/fskip_mask_shift.sv
// Logarithmic right shifter: moves the mask down by amt_i slots,
// filling the top with zeros.
module fskip_mask_shift #(
    parameter int MASK_W = 32,
    parameter int INC_W  = 4
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic [INC_W-1:0]  amt_i,
    output logic [MASK_W-1:0] mask_o
);

    logic [MASK_W-1:0] stage [INC_W+1];

    assign stage[0] = mask_i;

    genvar s;
    generate
        for (s = 0; s < INC_W; s++) begin : g_stage
            assign stage[s+1] = amt_i[s] ? (stage[s] >> (1 << s)) : stage[s];
        end
    endgenerate

    assign mask_o = stage[INC_W];

endmodule

// File: rtl/fskip_advance.sv
// Fast-skip program counter advance unit.
module fskip_advance #(
    parameter int MASK_W  = fskip_pkg::FSK_MASK_W,
    parameter int MAX_RUN = fskip_pkg::FSK_MAX_RUN,
    localparam int INC_W  = fskip_pkg::fsk_inc_width(MAX_RUN)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              fast_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              adv_i,
    input  logic              shared_i,
    output logic [INC_W-1:0]  pc_inc_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              squash_o,
    output logic              slow_o,
    output logic              active_o
);

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              fast;
        logic              slow;
    } fsk_state_t;

    fsk_state_t st_d, st_q;

    logic              run_en;
    logic [INC_W-1:0]  run_len;
    logic              run_capped;
    logic [INC_W-1:0]  inc;
    logic [MASK_W-1:0] mask_shifted;

    // Elimination only in fast mode and outside shared memory.
    assign run_en = st_q.fast & ~shared_i;

    fskip_run_count #(
        .MASK_W (MASK_W),
        .MAX_RUN(MAX_RUN),
        .INC_W  (INC_W)
    ) i_run (
        .mask_i  (st_q.mask),
        .enable_i(run_en),
        .run_o   (run_len),
        .capped_o(run_capped)
    );

    assign inc = run_len + INC_W'(1);

    fskip_mask_shift #(
        .MASK_W(MASK_W),
        .INC_W (INC_W)
    ) i_shift (
        .mask_i(st_q.mask),
        .amt_i (inc),
        .mask_o(mask_shifted)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            // A new sequence replaces whatever was running; its first
            // slot can only be squashed the ordinary way.
            st_d.mask = mask_i;
            st_d.fast = fast_i;
            st_d.slow = mask_i[0];
        end else if (adv_i) begin
            st_d.mask = mask_shifted;
            st_d.slow = mask_shifted[0] & (run_capped | ~run_en);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_inc_o = inc;
    assign mask_o   = st_q.mask;
    assign squash_o = st_q.mask[0];
    assign slow_o   = st_q.slow;
    assign active_o = |st_q.mask;

endmodule

// File: rtl/fskip_advance_chk.sv
module fskip_advance_chk #(
    parameter int MASK_W  = 32,
    parameter int MAX_RUN = 7,
    parameter int INC_W   = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [MASK_W-1:0] mask_i,
    input logic              adv_i,
    input logic              shared_i,
    input logic [INC_W-1:0]  pc_inc_o,
    input logic [MASK_W-1:0] mask_o,
    input logic              squash_o,
    input logic              slow_o,
    input logic              active_o
);

    AST_INC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_inc_o >= INC_W'(1)) && (pc_inc_o <= INC_W'(MAX_RUN + 1))); // R4

    AST_SHARED_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shared_i |-> (pc_inc_o == INC_W'(1))); // R5

    AST_LOAD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (mask_o == $past(mask_i))); // R2

    AST_HOLD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !adv_i) |=> $stable(mask_o)); // R2

    AST_FIRST_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (slow_o == $past(mask_i[0]))); // R3

    AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !start_i) |=> (mask_o == ($past(mask_o) >> $past(pc_inc_o)))); // R6

    AST_SLOW_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slow_o |-> squash_o); // R7

    AST_IDLE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_o |-> (pc_inc_o == INC_W'(1))); // R9

endmodule

bind fskip_advance fskip_advance_chk #(
    .MASK_W (MASK_W),
    .MAX_RUN(MAX_RUN),
    .INC_W  (INC_W)
) i_fskip_advance_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mask_i  (mask_i),
    .adv_i   (adv_i),
    .shared_i(shared_i),
    .pc_inc_o(pc_inc_o),
    .mask_o  (mask_o),
    .squash_o(squash_o),
    .slow_o  (slow_o),
    .active_o(active_o)
);

// File: tb/test_fskip_advance.sv
module test_fskip_advance;

    localparam int CLK_PERIOD = 10;
    localparam int MASK_W     = 32;
    localparam int MAX_RUN    = 7;
    localparam int INC_W      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              fast = 1'b0;
    logic [MASK_W-1:0] mask = '0;
    logic              adv = 1'b0;
    logic              shared = 1'b0;
    logic [INC_W-1:0]  pc_inc;
    logic [MASK_W-1:0] mask_out;
    logic              squash;
    logic              slow;
    logic              active;

    int checks = 0;
    int errors = 0;

    // Reference state, advanced one slot at a time.
    logic [MASK_W-1:0] m_mask = '0;
    logic              m_fast = 1'b0;
    logic              m_slow = 1'b0;
    string             mask_tag = "R1";
    string             slow_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    fskip_advance #(
        .MASK_W (MASK_W),
        .MAX_RUN(MAX_RUN)
    ) i_fskip_advance (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .fast_i  (fast),
        .mask_i  (mask),
        .adv_i   (adv),
        .shared_i(shared),
        .pc_inc_o(pc_inc),
        .mask_o  (mask_out),
        .squash_o(squash),
        .slow_o  (slow),
        .active_o(active)
    );

    task automatic check(input string req, input logic [MASK_W-1:0] act,
                         input logic [MASK_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Slots that may be dropped after the current one.
    function automatic int ref_run(input logic [MASK_W-1:0] mk, input logic fm,
                                   input logic sh);
        int n = 0;
        if (!fm || sh) return 0;
        for (int i = 1; i < MASK_W; i++) begin
            if (!mk[i] || n == MAX_RUN) break;
            n++;
        end
        return n;
    endfunction

    task automatic step(input logic st, input logic fm, input logic [MASK_W-1:0] mk,
                        input logic av, input logic sh);
        int r;
        @(negedge clk);
        start  = st;
        fast   = fm;
        mask   = mk;
        adv    = av;
        shared = sh;
        #1;
        r = ref_run(m_mask, m_fast, sh);
        check((m_fast && !sh) ? "R4 increment" : "R5 increment",
              MASK_W'(pc_inc), MASK_W'(r + 1));
        check(mask_tag, mask_out, m_mask);
        check("R2 squash", MASK_W'(squash), MASK_W'(m_mask[0]));
        check(slow_tag, MASK_W'(slow), MASK_W'(m_slow));
        check("R9 active", MASK_W'(active), MASK_W'(m_mask != '0));
        // model update for the coming edge
        if (st) begin
            mask_tag = av ? "R8 load over advance" : "R2 load";
            slow_tag = "R3 first slot";
            m_mask = mk;
            m_fast = fm;
            m_slow = mk[0];
        end else if (av) begin
            mask_tag = "R6 shift";
            slow_tag = "R7 slow flag";
            for (int k = 0; k < r + 1; k++) m_mask = m_mask >> 1;
            m_slow = m_mask[0] && (r == MAX_RUN || sh || !m_fast);
        end else begin
            mask_tag = "R2 hold";
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check("R1 mask", mask_out, '0);
        check("R1 increment", MASK_W'(pc_inc), 1);
        check("R1 flags", MASK_W'({squash, slow, active}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Capped run: first slot clear, then long run of ones.
        step(1, 1, 32'hFFFF_FFFE, 0, 0);
        step(0, 0, 32'h1234_5678, 0, 0);   // R2 inputs ignored while idle
        repeat (6) step(0, 1, '0, 1, 0);
        // First slot set, fast, short run.
        step(1, 1, 32'h0000_000F, 0, 0);
        repeat (3) step(0, 0, '0, 1, 0);
        // Shared memory: one slot per step.
        step(1, 1, 32'h0000_00FF, 0, 1);
        repeat (4) step(0, 0, '0, 1, 1);
        // Leave shared memory mid-sequence.
        repeat (2) step(0, 0, '0, 1, 0);
        // Normal mode never eliminates.
        step(1, 0, 32'hF0F0_F0F0, 0, 0);
        repeat (5) step(0, 0, '0, 1, 0);
        // Load and advance together (R8).
        step(1, 1, 32'hFFFF_FFFF, 0, 0);
        step(1, 1, 32'h0000_0006, 1, 0);
        repeat (2) step(0, 0, '0, 1, 0);
        // Zero load ends skipping (R9).
        step(1, 1, 32'hFFFF_FFFF, 0, 0);
        step(1, 1, '0, 0, 0);
        repeat (2) step(0, 1, '0, 1, 0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic st;
            logic [MASK_W-1:0] mk;
            st = ($urandom_range(0, 15) == 0);
            mk = $urandom();
            if ($urandom_range(0, 3) == 0) mk = mk | (mk >> 1) | (mk >> 2);
            step(st, 1'($urandom_range(0, 3) != 0), mk,
                 1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 5) == 0));
        end
        step(0, 0, '0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule